// File: doc/BRIEF.md
# Hardware Cursor Overlay Plane

This block places a square ARGB cursor over the pixel stream of one display pipe. For each pixel coordinate that the timing path presents, it decides whether the pixel falls under the cursor. It reads the matching cursor texel from a small local texel store, which stands in for the fetched cursor surface. It then blends that texel over the underlying pixel, using the texel's own alpha. The cursor can be 64, 128 or 256 pixels on a side. The plane can also be switched off.

The cursor's position is given as a sign bit plus a magnitude on each axis. This lets the cursor hang partly off the left or top edge of the screen. Software stages the size, the position and the surface page number with one strobe. The whole set takes effect at the next frame-start pulse, so a frame never shows a mix of old and new settings.

When a frame starts with the cursor enabled but not overlapping the visible area by even one pixel, the block raises a fault flag for that frame and shows only underlying pixels.

A three-state machine holds the plane's condition. The states are ST_OFF (plane disabled), ST_SHOW (cursor drawn) and ST_FAULT (enabled but no overlap). At each frame start the machine takes one of three transitions, from whatever state it is in:
- T_LOAD_OFF: the newly loaded mode is disabled.
- T_LOAD_SHOW: an enabled mode is loaded and overlaps the visible area.
- T_LOAD_FAULT: an enabled mode is loaded and does not overlap the visible area.

Without a frame-start pulse the state holds.

Top module: `cursor_overlay`

## Requirements
- R1: `cfg_mode` encodes the plane mode: 0 = disabled, 1 = 64x64, 2 = 128x128, 3 = 256x256 cursor.
- R2: Each axis position is a sign bit (`cfg_x_neg`/`cfg_y_neg`, 1 = negative) plus a magnitude, so negative zero means zero. A pixel (x, y) lies under the cursor when both x-px and y-py are in [0, size-1], where (px, py) is the signed position.
- R3: The texel for offset (col, row) inside the cursor is read from word (page*64 + row*size + col) modulo the store depth (2048 by default). Texel bits 31:24 are alpha, 23:16 red, 15:8 green and 7:0 blue.
- R4: For a covered pixel, each channel of the output is floor((A*C + (255-A)*U)/255), where C is the texel channel and U the underlying channel. Pixel bits 23:16 are red, 15:8 green and 7:0 blue. Alpha 0 gives U and alpha 255 gives C.
- R5: `out_valid` and `out_pix` follow `pix_valid` and its pixel exactly two clock cycles later.
- R6: A `cfg_arm` strobe only stages values. They take effect at the first `frame_start` after the strobe. A strobe in the same cycle as `frame_start` waits for the following one.
- R7: With the disabled mode active, every output pixel equals the underlying pixel.
- R8: At a frame start that loads an enabled mode with no overlap of the SCR_W x SCR_H area (px >= SCR_W, or px+size <= 0, or the same on y), `ovl_err` rises and stays high until a later frame start. While it is high, output pixels equal underlying pixels.
- R9: After reset, `out_valid` is 0, `out_pix` is 0, `ovl_err` is 0 and the plane is disabled.
- R10: A cycle with `tex_we` high writes `tex_wdata` to word `tex_waddr` of the texel store. Later reads return the new texel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cfg_arm | input | 1 | Stages the configuration inputs |
| cfg_mode | input | 2 | Plane mode (R1) |
| cfg_x_neg | input | 1 | Sign of horizontal position |
| cfg_x_mag | input | MAG_W | Magnitude of horizontal position |
| cfg_y_neg | input | 1 | Sign of vertical position |
| cfg_y_mag | input | MAG_W | Magnitude of vertical position |
| cfg_page | input | PAGE_NUM_W | Cursor surface page number |
| tex_we | input | 1 | Texel store write enable |
| tex_waddr | input | TA_W | Texel store write address |
| tex_wdata | input | 4*CH_W | ARGB texel to write |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_x | input | CW | Pixel column |
| pix_y | input | CW | Pixel row |
| under_pix | input | 3*CH_W | Underlying RGB pixel |
| out_valid | output | 1 | Blended pixel present |
| out_pix | output | 3*CH_W | Blended RGB pixel |
| ovl_err | output | 1 | Enabled cursor has no visible overlap |

## Verification
The checker follows these rules on every cycle:
- the two-cycle pixel latency;
- the rule that the active mode and the fault flag change only after a frame-start pulse;
- the fact that a fault never occurs with the plane disabled;
- pass-through of the underlying pixel whenever the plane is off or faulted.

Only the bench's scenarios can show the rest. That covers the exact blended colour values, the coverage window at each edge for negative and positive positions, the texel address arithmetic including its wrap, and the one-pixel overlap boundary that separates showing from faulting.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

    typedef enum logic [1:0] {
        CM_OFF = 2'd0,
        CM_64  = 2'd1,
        CM_128 = 2'd2,
        CM_256 = 2'd3
    } cmode_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SHOW  = 2'd1,
        ST_FAULT = 2'd2
    } cstate_t;

    // Side length in pixels for a mode; zero when disabled.
    function automatic logic [8:0] side_of(input cmode_t m);
        logic [8:0] s;
        unique case (m)
            CM_64:   s = 9'd64;
            CM_128:  s = 9'd128;
            CM_256:  s = 9'd256;
            default: s = 9'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cursor_ctl.sv
module cursor_ctl
    import cursor_ovl_pkg::*;
#(
    parameter int MAG_W      = 12,
    parameter int PAGE_NUM_W = 5,
    parameter int SCR_W      = 640,
    parameter int SCR_H      = 480
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    cfg_arm,
    input  logic [1:0]              cfg_mode,
    input  logic                    cfg_x_neg,
    input  logic [MAG_W-1:0]        cfg_x_mag,
    input  logic                    cfg_y_neg,
    input  logic [MAG_W-1:0]        cfg_y_mag,
    input  logic [PAGE_NUM_W-1:0]   cfg_page,
    output cmode_t                  act_mode,
    output logic signed [MAG_W:0]   act_px,
    output logic signed [MAG_W:0]   act_py,
    output logic [PAGE_NUM_W-1:0]   act_page,
    output logic                    show_en,
    output logic                    ovl_err
);

    localparam int OW = MAG_W + 3;
    localparam logic signed [OW-1:0] SW_S = OW'(SCR_W);
    localparam logic signed [OW-1:0] SH_S = OW'(SCR_H);

    cmode_t                   stg_mode;
    logic signed [MAG_W:0]    stg_px, stg_py;
    logic [PAGE_NUM_W-1:0]    stg_page;
    logic signed [MAG_W:0]    new_px, new_py;

    cstate_t state, state_nx;

    logic signed [OW-1:0] sx, sy, sz;
    logic                 x_hit_area, y_hit_area, overlaps;

    // Sign-magnitude to two's complement
    always_comb begin
        new_px = cfg_x_neg ? -$signed({1'b0, cfg_x_mag}) : $signed({1'b0, cfg_x_mag});
        new_py = cfg_y_neg ? -$signed({1'b0, cfg_y_mag}) : $signed({1'b0, cfg_y_mag});
    end

    // Staging registers: written by the arm strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_mode <= CM_OFF;
            stg_px   <= '0;
            stg_py   <= '0;
            stg_page <= '0;
        end else if (cfg_arm) begin
            stg_mode <= cmode_t'(cfg_mode);
            stg_px   <= new_px;
            stg_py   <= new_py;
            stg_page <= cfg_page;
        end
    end

    // Active registers: loaded from staging at frame start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= CM_OFF;
            act_px   <= '0;
            act_py   <= '0;
            act_page <= '0;
        end else if (frame_start) begin
            act_mode <= stg_mode;
            act_px   <= stg_px;
            act_py   <= stg_py;
            act_page <= stg_page;
        end
    end

    // Visible-area overlap of the staged window
    always_comb begin
        sx = {{2{stg_px[MAG_W]}}, stg_px};
        sy = {{2{stg_py[MAG_W]}}, stg_py};
        sz = {{(OW-9){1'b0}}, side_of(stg_mode)};
        x_hit_area = (sx < SW_S) && ((sx + sz) > 0);
        y_hit_area = (sy < SH_S) && ((sy + sz) > 0);
        overlaps   = x_hit_area && y_hit_area;
    end

    // Next-state logic: transitions happen at frame start only
    always_comb begin
        state_nx = state;
        if (frame_start) begin
            if (stg_mode == CM_OFF)
                state_nx = ST_OFF;      // T_LOAD_OFF
            else if (overlaps)
                state_nx = ST_SHOW;     // T_LOAD_SHOW
            else
                state_nx = ST_FAULT;    // T_LOAD_FAULT
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    // Outputs decoded from state
    always_comb begin
        show_en = 1'b0;
        ovl_err = 1'b0;
        unique case (state)
            ST_OFF:   ;
            ST_SHOW:  show_en = 1'b1;
            ST_FAULT: ovl_err = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
    import cursor_ovl_pkg::*;
#(
    parameter int CW         = 12,
    parameter int MAG_W      = 12,
    parameter int PAGE_NUM_W = 5,
    parameter int PAGE_SH    = 6,
    parameter int TA_W       = 11
) (
    input  logic [CW-1:0]           pix_x,
    input  logic [CW-1:0]           pix_y,
    input  cmode_t                  act_mode,
    input  logic signed [MAG_W:0]   act_px,
    input  logic signed [MAG_W:0]   act_py,
    input  logic [PAGE_NUM_W-1:0]   act_page,
    input  logic                    show_en,
    output logic                    hit,
    output logic [TA_W-1:0]         rd_addr
);

    localparam int DW = ((CW > MAG_W) ? CW : MAG_W) + 2;

    logic signed [DW-1:0] dx, dy, sz;
    logic [15:0]          offs;
    logic [TA_W-1:0]      page_base;

    always_comb begin
        dx = $signed({{(DW-CW){1'b0}}, pix_x}) - $signed({{(DW-MAG_W-1){act_px[MAG_W]}}, act_px});
        dy = $signed({{(DW-CW){1'b0}}, pix_y}) - $signed({{(DW-MAG_W-1){act_py[MAG_W]}}, act_py});
        sz = $signed({{(DW-9){1'b0}}, side_of(act_mode)});
        hit = show_en && (dx >= 0) && (dx < sz) && (dy >= 0) && (dy < sz);
    end

    // Row-major offset inside the cursor; side is a power of two
    always_comb begin
        unique case (act_mode)
            CM_64:   offs = {4'd0, dy[5:0], dx[5:0]};
            CM_128:  offs = {2'd0, dy[6:0], dx[6:0]};
            CM_256:  offs = {dy[7:0], dx[7:0]};
            default: offs = '0;
        endcase
        page_base = TA_W'({act_page, {PAGE_SH{1'b0}}});
        rd_addr   = page_base + TA_W'(offs);
    end

endmodule

// File: rtl/cursor_texram.sv
module cursor_texram #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/cursor_blend.sv
module cursor_blend #(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_hit,
    input  logic [4*CH_W-1:0] texel,
    input  logic [3*CH_W-1:0] under,
    output logic              out_valid,
    output logic [3*CH_W-1:0] out_pix
);

    localparam int AW = 2*CH_W + 1;
    localparam logic [CH_W-1:0] AMAX = {CH_W{1'b1}};

    logic [CH_W-1:0]   alpha;
    logic [3*CH_W-1:0] mixed;

    assign alpha = texel[4*CH_W-1:3*CH_W];

    for (genvar c = 0; c < 3; c++) begin : g_chan
        logic [CH_W-1:0] tc, uc;
        logic [AW-1:0]   acc;
        always_comb begin
            tc  = texel[c*CH_W +: CH_W];
            uc  = under[c*CH_W +: CH_W];
            acc = AW'(alpha) * AW'(tc) + AW'(AMAX - alpha) * AW'(uc);
            mixed[c*CH_W +: CH_W] = CH_W'(acc / AW'(AMAX));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_pix   <= in_hit ? mixed : under;
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_ovl_pkg::*;
#(
    parameter int CW         = 12,
    parameter int MAG_W      = 12,
    parameter int CH_W       = 8,
    parameter int TEX_DEPTH  = 2048,
    parameter int PAGE_SH    = 6,
    parameter int SCR_W      = 640,
    parameter int SCR_H      = 480,
    parameter int TA_W       = $clog2(TEX_DEPTH),
    parameter int PAGE_NUM_W = TA_W - PAGE_SH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  cfg_arm,
    input  logic [1:0]            cfg_mode,
    input  logic                  cfg_x_neg,
    input  logic [MAG_W-1:0]      cfg_x_mag,
    input  logic                  cfg_y_neg,
    input  logic [MAG_W-1:0]      cfg_y_mag,
    input  logic [PAGE_NUM_W-1:0] cfg_page,
    input  logic                  tex_we,
    input  logic [TA_W-1:0]       tex_waddr,
    input  logic [4*CH_W-1:0]     tex_wdata,
    input  logic                  pix_valid,
    input  logic [CW-1:0]         pix_x,
    input  logic [CW-1:0]         pix_y,
    input  logic [3*CH_W-1:0]     under_pix,
    output logic                  out_valid,
    output logic [3*CH_W-1:0]     out_pix,
    output logic                  ovl_err
);

    localparam int PIX_W = 3*CH_W;
    localparam int TEX_W = 4*CH_W;

    cmode_t                  act_mode;
    logic signed [MAG_W:0]   act_px, act_py;
    logic [PAGE_NUM_W-1:0]   act_page;
    logic                    show_en;
    logic                    hit;
    logic [TA_W-1:0]         rd_addr;
    logic [TEX_W-1:0]        texel;

    logic                    s1_valid, s1_hit;
    logic [PIX_W-1:0]        s1_under;

    cursor_ctl #(
        .MAG_W(MAG_W), .PAGE_NUM_W(PAGE_NUM_W), .SCR_W(SCR_W), .SCR_H(SCR_H)
    ) i_ctl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_arm(cfg_arm), .cfg_mode(cfg_mode),
        .cfg_x_neg(cfg_x_neg), .cfg_x_mag(cfg_x_mag),
        .cfg_y_neg(cfg_y_neg), .cfg_y_mag(cfg_y_mag),
        .cfg_page(cfg_page),
        .act_mode(act_mode), .act_px(act_px), .act_py(act_py),
        .act_page(act_page), .show_en(show_en), .ovl_err(ovl_err)
    );

    cursor_hit #(
        .CW(CW), .MAG_W(MAG_W), .PAGE_NUM_W(PAGE_NUM_W), .PAGE_SH(PAGE_SH), .TA_W(TA_W)
    ) i_hit (
        .pix_x(pix_x), .pix_y(pix_y), .act_mode(act_mode),
        .act_px(act_px), .act_py(act_py), .act_page(act_page),
        .show_en(show_en), .hit(hit), .rd_addr(rd_addr)
    );

    cursor_texram #(
        .DEPTH(TEX_DEPTH), .AW(TA_W), .DW(TEX_W)
    ) i_ram (
        .clk(clk), .we(tex_we), .waddr(tex_waddr), .wdata(tex_wdata),
        .raddr(rd_addr), .rdata(texel)
    );

    // Stage 1: align pixel with the registered texel read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_under <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_hit   <= pix_valid && hit;
            s1_under <= under_pix;
        end
    end

    cursor_blend #(
        .CH_W(CH_W)
    ) i_blend (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_hit(s1_hit),
        .texel(texel), .under(s1_under),
        .out_valid(out_valid), .out_pix(out_pix)
    );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             pix_valid,
    input logic [PIX_W-1:0] under_pix,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic             ovl_err,
    input logic [1:0]       act_mode
);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 out_valid); // R5

    AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ##1 !out_valid); // R5

    AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_mode)); // R6

    AST_ERR_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ovl_err)); // R8

    AST_ERR_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_err |-> (act_mode != 2'd0)); // R8

    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && act_mode == 2'd0) |=> ##1 (out_pix == $past(under_pix, 2))); // R7

    AST_FAULT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ovl_err) |=> ##1 (out_pix == $past(under_pix, 2))); // R8

endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(3*CH_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_valid(pix_valid), .under_pix(under_pix),
    .out_valid(out_valid), .out_pix(out_pix),
    .ovl_err(ovl_err), .act_mode(act_mode)
);

// File: tb/test_cursor_overlay.sv
`timescale 1ns/1ps
module test_cursor_overlay;

    localparam int SCR_W = 640;
    localparam int SCR_H = 480;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        cfg_arm = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_x_neg = 1'b0;
    logic [11:0] cfg_x_mag = '0;
    logic        cfg_y_neg = 1'b0;
    logic [11:0] cfg_y_mag = '0;
    logic [4:0]  cfg_page = '0;
    logic        tex_we = 1'b0;
    logic [10:0] tex_waddr = '0;
    logic [31:0] tex_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_x = '0;
    logic [11:0] pix_y = '0;
    logic [23:0] under_pix = '0;
    logic        out_valid;
    logic [23:0] out_pix;
    logic        ovl_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] patch = 32'h0;
    bit patched = 1'b0;

    always #2.5 clk = ~clk;

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_arm(cfg_arm), .cfg_mode(cfg_mode),
        .cfg_x_neg(cfg_x_neg), .cfg_x_mag(cfg_x_mag),
        .cfg_y_neg(cfg_y_neg), .cfg_y_mag(cfg_y_mag),
        .cfg_page(cfg_page),
        .tex_we(tex_we), .tex_waddr(tex_waddr), .tex_wdata(tex_wdata),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .under_pix(under_pix),
        .out_valid(out_valid), .out_pix(out_pix), .ovl_err(ovl_err)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        xn;
        logic [11:0] xm;
        logic        yn;
        logic [11:0] ym;
        logic [4:0]  page;
        logic [11:0] x;
        logic [11:0] y;
        logic [23:0] u;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 12'd10,  1'b0, 12'd20,  5'd0,  12'd10,  12'd20,  24'h102030},
        '{2'd1, 1'b0, 12'd10,  1'b0, 12'd20,  5'd0,  12'd73,  12'd83,  24'h405060},
        '{2'd1, 1'b0, 12'd10,  1'b0, 12'd20,  5'd0,  12'd74,  12'd20,  24'h0a0b0c},
        '{2'd1, 1'b0, 12'd10,  1'b0, 12'd20,  5'd0,  12'd9,   12'd20,  24'hc0ffee},
        '{2'd2, 1'b1, 12'd30,  1'b1, 12'd5,   5'd2,  12'd0,   12'd0,   24'h123456},
        '{2'd2, 1'b1, 12'd30,  1'b1, 12'd5,   5'd2,  12'd97,  12'd0,   24'h808080},
        '{2'd2, 1'b1, 12'd30,  1'b1, 12'd5,   5'd2,  12'd98,  12'd0,   24'h777777},
        '{2'd3, 1'b0, 12'd600, 1'b0, 12'd400, 5'd3,  12'd639, 12'd479, 24'hff0000},
        '{2'd3, 1'b0, 12'd600, 1'b0, 12'd400, 5'd31, 12'd855, 12'd655, 24'h00ff00},
        '{2'd0, 1'b0, 12'd0,   1'b0, 12'd0,   5'd0,  12'd5,   12'd5,   24'h0000ff},
        '{2'd1, 1'b1, 12'd0,   1'b1, 12'd0,   5'd1,  12'd0,   12'd0,   24'h345678},
        '{2'd1, 1'b1, 12'd63,  1'b1, 12'd63,  5'd4,  12'd0,   12'd0,   24'h9abcde}
    };

    function automatic logic [31:0] tex_fn(input int a);
        logic [10:0] w;
        w = a[10:0];
        if (patched && w == 11'd0) return patch;
        return {w[3:0], w[3:0], w[10:3], ~w[7:0], w[7:0] ^ 8'h5a};
    endfunction

    function automatic int side(input logic [1:0] m);
        return (m == 2'd1) ? 64 : (m == 2'd2) ? 128 : (m == 2'd3) ? 256 : 0;
    endfunction

    function automatic bit exp_err(input vec_t v);
        int px, py, s;
        s  = side(v.mode);
        px = v.xn ? -int'(v.xm) : int'(v.xm);
        py = v.yn ? -int'(v.ym) : int'(v.ym);
        if (v.mode == 2'd0) return 1'b0;
        return !((px < SCR_W) && (px + s > 0) && (py < SCR_H) && (py + s > 0));
    endfunction

    function automatic logic [23:0] exp_pix(input vec_t v);
        int px, py, s, dx, dy, a, addr;
        logic [31:0] t;
        logic [23:0] r;
        s  = side(v.mode);
        px = v.xn ? -int'(v.xm) : int'(v.xm);
        py = v.yn ? -int'(v.ym) : int'(v.ym);
        dx = int'(v.x) - px;
        dy = int'(v.y) - py;
        if (v.mode == 2'd0 || exp_err(v) || dx < 0 || dy < 0 || dx >= s || dy >= s)
            return v.u;
        addr = (int'(v.page) * 64 + dy * s + dx) % DEPTH;
        t = tex_fn(addr);
        a = int'(t[31:24]);
        for (int c = 0; c < 3; c++)
            r[c*8 +: 8] = 8'((a * int'(t[c*8 +: 8]) + (255 - a) * int'(v.u[c*8 +: 8])) / 255);
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic stage(input vec_t v);
        @(negedge clk);
        cfg_arm = 1'b1; cfg_mode = v.mode; cfg_x_neg = v.xn; cfg_x_mag = v.xm;
        cfg_y_neg = v.yn; cfg_y_mag = v.ym; cfg_page = v.page;
        @(negedge clk);
        cfg_arm = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic probe(input vec_t v, output logic [23:0] got, output logic mid_valid);
        pix_valid = 1'b1; pix_x = v.x; pix_y = v.y; under_pix = v.u;
        @(negedge clk);
        pix_valid = 1'b0;
        mid_valid = out_valid;
        @(negedge clk);
        got = out_pix;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] got;
        logic        mid;
        vec_t v;

        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 out_valid after reset", 32'(out_valid), 32'h0);
        check("R9 out_pix after reset", 32'(out_pix), 32'h0);
        check("R9 ovl_err after reset", 32'(ovl_err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7/R9: plane starts disabled, so a pixel passes through
        v = '{2'd0, 1'b0, 12'd0, 1'b0, 12'd0, 5'd0, 12'd3, 12'd3, 24'h5a5a5a};
        probe(v, got, mid);
        check("R9 R7 disabled at reset passthru", 32'(got), 32'h5a5a5a);

        // R10: load the texel store
        for (int a = 0; a < DEPTH; a++) begin
            tex_we = 1'b1; tex_waddr = 11'(a); tex_wdata = tex_fn(a);
            @(negedge clk);
        end
        tex_we = 1'b0;

        // Table walk: R1 R2 R3 R4 R7 R8
        for (int i = 0; i < NV; i++) begin
            stage(VECS[i]);
            pulse_frame();
            check($sformatf("R8 R1 vec %0d ovl_err", i), 32'(ovl_err), 32'(exp_err(VECS[i])));
            probe(VECS[i], got, mid);
            check($sformatf("R4 R2 R3 vec %0d pixel", i), 32'(got), 32'(exp_pix(VECS[i])));
        end

        // R5: exact two-cycle latency
        v = '{2'd1, 1'b0, 12'd0, 1'b0, 12'd0, 5'd0, 12'd1, 12'd0, 24'h111111};
        stage(v); pulse_frame();
        probe(v, got, mid);
        check("R5 out_valid low after one cycle", 32'(mid), 32'h0);
        check("R5 out_valid high after two cycles", 32'(out_valid), 32'h1);
        @(negedge clk);
        check("R5 out_valid drops after one pulse", 32'(out_valid), 32'h0);

        // R6: arm without frame start leaves the cursor showing
        v = '{2'd0, 1'b0, 12'd0, 1'b0, 12'd0, 5'd0, 12'd1, 12'd0, 24'h111111};
        stage(v);
        v.mode = 2'd1;
        probe(v, got, mid);
        check("R6 staged only, old config kept", 32'(got), 32'(exp_pix(v)));
        pulse_frame();
        v.mode = 2'd0;
        probe(v, got, mid);
        check("R6 frame start applies staged off", 32'(got), 32'h111111);

        // R6: arm in the same cycle as frame start waits for the next frame
        v = '{2'd1, 1'b0, 12'd0, 1'b0, 12'd0, 5'd0, 12'd1, 12'd0, 24'h222222};
        @(negedge clk);
        frame_start = 1'b1; cfg_arm = 1'b1; cfg_mode = v.mode;
        cfg_x_neg = 1'b0; cfg_x_mag = '0; cfg_y_neg = 1'b0; cfg_y_mag = '0; cfg_page = '0;
        @(negedge clk);
        frame_start = 1'b0; cfg_arm = 1'b0;
        probe(v, got, mid);
        check("R6 same-cycle arm not yet active", 32'(got), 32'h222222);
        pulse_frame();
        probe(v, got, mid);
        check("R6 same-cycle arm active next frame", 32'(got), 32'(exp_pix(v)));

        // R8: fault off the right edge, pixel inside window but off screen
        v = '{2'd3, 1'b0, 12'd640, 1'b0, 12'd0, 5'd0, 12'd650, 12'd10, 24'h333333};
        stage(v); pulse_frame();
        check("R8 fault raised at right edge", 32'(ovl_err), 32'h1);
        probe(v, got, mid);
        check("R8 fault passes underlying", 32'(got), 32'h333333);
        v = '{2'd1, 1'b0, 12'd5, 1'b0, 12'd5, 5'd0, 12'd5, 12'd5, 24'h333333};
        stage(v);
        check("R8 fault held without frame start", 32'(ovl_err), 32'h1);
        pulse_frame();
        check("R8 fault cleared at frame start", 32'(ovl_err), 32'h0);

        // R8: zero overlap at the left edge (px + size == 0)
        v = '{2'd1, 1'b1, 12'd64, 1'b0, 12'd0, 5'd0, 12'd0, 12'd0, 24'h444444};
        stage(v); pulse_frame();
        check("R8 no overlap at px=-64", 32'(ovl_err), 32'h1);

        // R10: overwrite texel 0 with opaque colour and read it back
        @(negedge clk);
        tex_we = 1'b1; tex_waddr = 11'd0; tex_wdata = 32'hff13579b;
        @(negedge clk);
        tex_we = 1'b0;
        patch = 32'hff13579b; patched = 1'b1;
        v = '{2'd1, 1'b0, 12'd0, 1'b0, 12'd0, 5'd0, 12'd0, 12'd0, 24'h555555};
        stage(v); pulse_frame();
        probe(v, got, mid);
        check("R10 R4 rewritten opaque texel", 32'(got), 32'h13579b);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule